// File: doc/BRIEF.md
# Sign-Controlled Multiply-Accumulate Term

This combinational unit forms one signed multiply-accumulate term. The product of two signed 8-bit factors is added to or subtracted from a signed 16-bit offset. A single control bit picks the direction. The result is a signed 16-bit value that wraps in two's complement.

The unit never negates the product after the multiply. When subtraction is selected, the first factor is negated at the multiplier input instead. That factor is first widened to 9 bits, so negating its most negative value stays exact. The unit is meant to sit inside a wider arithmetic path of a larger datapath, where one carry-propagating sum is wanted per term.

Top module: `addsub_mac`

## Requirements
- R1: With `neg_sel` = 0, `z` equals `c + a*b` reduced modulo 2^16 to a signed 16-bit value.
- R2: With `neg_sel` = 1, `z` equals `c - a*b` reduced modulo 2^16 to a signed 16-bit value.
- R3: With `a` = -128, `b` = -128, `c` = 0 and `neg_sel` = 1, `z` is -16384. The negated factor +128 is exact.
- R4: With `a` = -128, `b` = 127, `c` = 0 and `neg_sel` = 1, `z` is 16256.
- R5: Results outside the 16-bit signed range wrap with no saturation. For example, `c` = 32767, `a` = `b` = 127 and `neg_sel` = 0 give -16640.
- R6: When either factor is 0, `z` equals `c` for both values of `neg_sel`.
- R7: The output is purely combinational. `z` follows the current inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Signed factor; this factor is negated when subtracting |
| b | input | 8 | Signed factor |
| c | input | 16 | Signed offset |
| neg_sel | input | 1 | 0 adds the product, 1 subtracts it |
| z | output | 16 | Signed result, wrapped modulo 2^16 |

## Verification
The assertions sample the unit only when all inputs are at known 0/1 values, and they take the output to be settled whenever they evaluate. The bench keeps within this in two ways. It drives every input from a single process on the falling clock edge. It compares the output half a period later, when the combinational path has long settled. The stimulus covers every pairing of the extreme factor values against extreme offsets in both directions, followed by random vectors.

// File: rtl/addsub_mac_pkg.sv
package addsub_mac_pkg;
  parameter int unsigned FACT_W = 8;
  parameter int unsigned ACC_W  = 16;
  localparam int unsigned NEG_W  = FACT_W + 1;
  localparam int unsigned PROD_W = NEG_W + FACT_W;

  typedef enum logic {DIR_ADD = 1'b0, DIR_SUB = 1'b1} dir_e;
endpackage

// File: rtl/addsub_mac_opneg.sv
module addsub_mac_opneg #(
  parameter int unsigned IN_W = 8,
  localparam int unsigned OUT_W = IN_W + 1
) (
  input  logic signed [IN_W-1:0]  op_in,
  input  logic                    do_neg,
  output logic signed [OUT_W-1:0] op_out
);
  logic signed [OUT_W-1:0] wide;

  always_comb begin
    wide   = OUT_W'(op_in);
    op_out = do_neg ? -wide : wide;
  end
endmodule

// File: rtl/addsub_mac_mul.sv
module addsub_mac_mul #(
  parameter int unsigned X_W = 9,
  parameter int unsigned Y_W = 8,
  localparam int unsigned P_W = X_W + Y_W
) (
  input  logic signed [X_W-1:0] x,
  input  logic signed [Y_W-1:0] y,
  output logic signed [P_W-1:0] p
);
  logic signed [P_W-1:0] xw;
  logic signed [P_W-1:0] yw;

  always_comb begin
    xw = P_W'(x);
    yw = P_W'(y);
    p  = xw * yw;
  end
endmodule

// File: rtl/addsub_mac_sum.sv
module addsub_mac_sum #(
  parameter int unsigned P_W = 17,
  parameter int unsigned S_W = 16
) (
  input  logic signed [P_W-1:0] term,
  input  logic signed [S_W-1:0] base,
  output logic signed [S_W-1:0] sum
);
  localparam int unsigned W = (P_W > S_W) ? P_W : S_W;
  logic signed [W-1:0] full;

  always_comb begin
    full = W'(term) + W'(base);
    sum  = full[S_W-1:0];
  end
endmodule

// File: rtl/addsub_mac.sv
module addsub_mac
  import addsub_mac_pkg::*;
(
  input  logic signed [FACT_W-1:0] a,
  input  logic signed [FACT_W-1:0] b,
  input  logic signed [ACC_W-1:0]  c,
  input  logic                     neg_sel,
  output logic signed [ACC_W-1:0]  z
);
  logic signed [NEG_W-1:0]  a_signed;
  logic signed [PROD_W-1:0] prod;
  dir_e                     dir;

  assign dir = dir_e'(neg_sel);

  addsub_mac_opneg #(.IN_W(FACT_W)) u_neg (
    .op_in  (a),
    .do_neg (dir == DIR_SUB),
    .op_out (a_signed)
  );

  addsub_mac_mul #(.X_W(NEG_W), .Y_W(FACT_W)) u_mul (
    .x (a_signed),
    .y (b),
    .p (prod)
  );

  addsub_mac_sum #(.P_W(PROD_W), .S_W(ACC_W)) u_sum (
    .term (prod),
    .base (c),
    .sum  (z)
  );
endmodule

// File: rtl/addsub_mac_chk.sv
module addsub_mac_chk
  import addsub_mac_pkg::*;
(
  input logic signed [FACT_W-1:0] a,
  input logic signed [FACT_W-1:0] b,
  input logic signed [ACC_W-1:0]  c,
  input logic                     neg_sel,
  input logic signed [ACC_W-1:0]  z
);
  logic signed [31:0] prod_i;
  logic signed [31:0] ref_i;

  always_comb begin
    prod_i = 32'(a) * 32'(b);
    ref_i  = neg_sel ? (32'(c) - prod_i) : (32'(c) + prod_i);
    if (!$isunknown({a, b, c, neg_sel, z})) begin
      if (!neg_sel) begin
        p_add_path_r1: assert (z == ref_i[ACC_W-1:0]);
      end else begin
        p_sub_path_r2: assert (z == ref_i[ACC_W-1:0]);
      end
      if (neg_sel && a == -FACT_W'(128) && b == -FACT_W'(128) && c == '0) begin
        p_min_neg_r3: assert (z == -ACC_W'(16384));
      end
      if (a == '0 || b == '0) begin
        p_zero_factor_r6: assert (z == c);
      end
    end
  end
endmodule

bind addsub_mac addsub_mac_chk u_chk (
  .a       (a),
  .b       (b),
  .c       (c),
  .neg_sel (neg_sel),
  .z       (z)
);

// File: tb/sim_addsub_mac.sv
module sim_addsub_mac;
  logic clk;
  logic signed [7:0]  a;
  logic signed [7:0]  b;
  logic signed [15:0] c;
  logic               neg_sel;
  logic signed [15:0] z;
  int total;
  int bad;
  bit done;

  addsub_mac u0 (.a(a), .b(b), .c(c), .neg_sel(neg_sel), .z(z));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic signed [15:0] model(int av, int bv, int cv, bit s);
    int r;
    r = s ? cv - av * bv : cv + av * bv;
    return 16'(r);
  endfunction

  task automatic apply(int av, int bv, int cv, bit s);
    @(negedge clk);
    a = 8'(av); b = 8'(bv); c = 16'(cv); neg_sel = s;
  endtask

  task automatic check(string req, logic signed [15:0] exp);
    @(posedge clk);
    #1;
    total++;
    if (z !== exp) begin
      bad++;
      $display("FAIL %s a=%0d b=%0d c=%0d sel=%0b got=%0d exp=%0d",
               req, a, b, c, neg_sel, z, exp);
    end
  endtask

  task automatic run(string req, int av, int bv, int cv, bit s);
    apply(av, bv, cv, s);
    check(req, model(av, bv, cv, s));
  endtask

  initial begin
    int ext[5] = '{-128, -1, 0, 1, 127};
    int cex[3] = '{-32768, 0, 32767};
    total = 0; bad = 0;
    a = '0; b = '0; c = '0; neg_sel = 1'b0;
    check("R7 idle", 16'sd0);
    // R3 and R4 fixed corners, values written out
    apply(-128, -128, 0, 1'b1); check("R3", -16'sd16384);
    apply(-128, 127, 0, 1'b1);  check("R4", 16'sd16256);
    // R5 wrap without saturation
    apply(127, 127, 32767, 1'b0); check("R5", -16'sd16640);
    apply(-128, 127, -32768, 1'b0); check("R5 low", 16'(-32768 - 16256));
    // R6 zero factor leaves offset
    apply(0, -77, 1234, 1'b1); check("R6", 16'sd1234);
    apply(99, 0, -4321, 1'b0); check("R6", -16'sd4321);
    // R7 output follows input change with no clock in between
    @(negedge clk); c = 16'sd500; a = 8'sd3; b = 8'sd4; neg_sel = 1'b1;
    #2; total++;
    if (z !== 16'sd488) begin
      bad++; $display("FAIL R7 got=%0d exp=488", z);
    end
    // R1/R2 extreme grid
    foreach (ext[i]) foreach (ext[j]) foreach (cex[k]) begin
      run("R1", ext[i], ext[j], cex[k], 1'b0);
      run("R2", ext[i], ext[j], cex[k], 1'b1);
    end
    // R1/R2 random vectors
    for (int n = 0; n < 2000; n++) begin
      int av, bv, cv;
      bit s;
      av = int'($signed(8'($urandom)));
      bv = int'($signed(8'($urandom)));
      cv = int'($signed(16'($urandom)));
      s  = 1'($urandom);
      run(s ? "R2" : "R1", av, bv, cv, s);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule